// File: doc/BRIEF.md
# Keyed Base-Address Register Unit

This block is a bus-slave register unit holding one 32-bit base register. The register tells the surrounding device where its internal RAM and register block live in the address space; bit 0 of the register is the valid flag. Every access to the unit is a full 32-bit transfer and must carry the CPU-space function code.

Two straps, sampled once after reset, choose the decode map. In the home map the base register sits at 0x0003FF00 and is always reachable. A slave device whose global chip select is disabled (mode strap 3'b110 with the chip-select-enable strap low) uses the relocated map. There the register moves to 0x0003FF04 and is locked. It is unlocked by a keyed write to 0x0003FF08 whose data bit 31 is set, and that write takes effect only while the device's own select-enable pin is high. Several identical devices on one bus can therefore receive the same broadcast sequence. Raising one device's pin at a time gives each a unique base value with no external glue logic.

Top module: `basereg_keyed_unit`

## Requirements
- R1: After reset the base register reads 0 (valid bit 0 low), the acknowledge is low and the unlock flag is clear.
- R2: In the home map (mode strap not 3'b110, or chip-select-enable strap high) the register is read and written at 0x0003FF00 without any keyed write.
- R3: In the relocated map (mode strap 3'b110 and chip-select-enable strap low) the register decodes at 0x0003FF04, and 0x0003FF00 is not acknowledged.
- R4: An access is decoded only when the function code equals 3'b111. Any other code gets no acknowledge and leaves the register unchanged.
- R5: In the relocated map, while the unlock flag is clear, reads and writes to 0x0003FF04 are not acknowledged and leave the register unchanged.
- R6: A write to 0x0003FF08 with data bit 31 = 1 sets the unlock flag only while the select-enable pin is high. The write is acknowledged either way.
- R7: A write to 0x0003FF08 with data bit 31 = 0 clears the unlock flag, whatever the pin level.
- R8: Each decoded access is acknowledged for exactly one cycle, in the cycle after the strobe is sampled. On a read acknowledge the read data equals the register value.
- R9: The straps are captured once after reset. Later strap changes do not move the decode map.
- R10: In the home map the keyed location 0x0003FF08 is not decoded and is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_strap | input | 3 | Configuration strap; 3'b110 selects the slave-without-chip-select mode |
| cs_en_strap | input | 1 | Global chip-select-enable strap; high keeps the home map |
| sel_en_pin | input | 1 | External select-enable pin that gates the keyed unlock |
| bus_strobe | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_fc | input | 3 | Function code; 3'b111 is CPU space |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack, 0 otherwise |
| bus_ack | output | 1 | One-cycle acknowledge |
| base_value | output | 32 | Current base register contents |
| base_valid | output | 1 | Bit 0 of the base register |

## Verification
The bench builds two instances with the default 32-bit address and data widths and the default decode addresses. One instance uses the home map and one the relocated map, and both sit on one shared bus. Broadcast keyed writes and per-instance select-enable pins show that each base register can be programmed on its own. A second reset with the mode strap at 3'b110 but the chip-select-enable strap high reaches the home-map case of that strap. A strap change after reset reaches the sample-once rule.

// File: rtl/basereg_pkg.sv
package basereg_pkg;

  typedef enum logic {
    MAP_HOME  = 1'b0,
    MAP_RELOC = 1'b1
  } map_mode_e;

  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_FC_W   = 3;
  localparam int unsigned DEF_MODE_W = 3;

  // Relocation happens only for the slave mode whose global chip select is off.
  function automatic map_mode_e pick_map(input logic mode_match, input logic cs_en);
    return (mode_match && !cs_en) ? MAP_RELOC : MAP_HOME;
  endfunction

endpackage

// File: rtl/basereg_rst_sync.sv
module basereg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/basereg_strap_capture.sv
module basereg_strap_capture #(
  parameter int unsigned      MODE_W     = basereg_pkg::DEF_MODE_W,
  parameter logic [MODE_W-1:0] RELOC_CODE = 3'b110
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [MODE_W-1:0]      mode_strap,
  input  logic                   cs_en_strap,
  output basereg_pkg::map_mode_e map_mode,
  output logic                   straps_ready
);
  import basereg_pkg::*;

  map_mode_e mode_q, mode_d;
  logic      ready_q, ready_d;
  logic      cap_en;

  always_comb begin
    cap_en  = !ready_q;
    mode_d  = mode_q;
    ready_d = ready_q;
    if (cap_en) begin
      mode_d  = pick_map(mode_strap == RELOC_CODE, cs_en_strap);
      ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MAP_HOME;
      ready_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      ready_q <= ready_d;
    end
  end

  assign map_mode     = mode_q;
  assign straps_ready = ready_q;

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> (ready_q && $stable(mode_q))) else $error("strap map moved"); // R9

endmodule

// File: rtl/basereg_decode.sv
module basereg_decode #(
  parameter int unsigned       ADDR_W     = basereg_pkg::DEF_ADDR_W,
  parameter int unsigned       FC_W       = basereg_pkg::DEF_FC_W,
  parameter logic [ADDR_W-1:0] HOME_ADDR  = 32'h0003_FF00,
  parameter logic [ADDR_W-1:0] RELOC_ADDR = 32'h0003_FF04,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 32'h0003_FF08,
  parameter logic [FC_W-1:0]   CPU_FC     = 3'b111
) (
  input  logic                   strobe,
  input  logic                   we,
  input  logic [FC_W-1:0]        fc,
  input  logic [ADDR_W-1:0]      addr,
  input  basereg_pkg::map_mode_e map_mode,
  input  logic                   straps_ready,
  output logic                   base_hit,
  output logic                   key_hit
);
  import basereg_pkg::*;

  logic              space_ok;
  logic [ADDR_W-1:0] base_sel;

  always_comb begin
    space_ok = strobe && straps_ready && (fc == CPU_FC);
    base_sel = (map_mode == MAP_RELOC) ? RELOC_ADDR : HOME_ADDR;
    base_hit = space_ok && (addr == base_sel);
    key_hit  = space_ok && we && (map_mode == MAP_RELOC) && (addr == KEY_ADDR);
  end

endmodule

// File: rtl/basereg_unlock.sv
module basereg_unlock (
  input  logic                   clk,
  input  logic                   rst_n,
  input  basereg_pkg::map_mode_e map_mode,
  input  logic                   key_hit,
  input  logic                   key_bit,
  input  logic                   sel_en_pin,
  output logic                   access_ok
);
  import basereg_pkg::*;

  logic unlock_q, unlock_d;

  always_comb begin
    unlock_d = unlock_q;
    if (key_hit) begin
      if (!key_bit) begin
        unlock_d = 1'b0;
      end else if (sel_en_pin) begin
        unlock_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
    end else begin
      unlock_q <= unlock_d;
    end
  end

  assign access_ok = (map_mode == MAP_HOME) || unlock_q;

  AST_UNLOCK_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_q) |-> ($past(key_hit) && $past(key_bit) && $past(sel_en_pin)))
    else $error("unlock without pin"); // R6

  AST_KEY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && !key_bit) |=> !unlock_q) else $error("relock failed"); // R7

endmodule

// File: rtl/basereg_store.sv
module basereg_store #(
  parameter int unsigned DATA_W = basereg_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_hit,
  input  logic              key_hit,
  input  logic              we,
  input  logic              access_ok,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              ack_q
);

  logic              wr_en, rd_en;
  logic [DATA_W-1:0] base_d, rdata_d;
  logic              ack_d;

  always_comb begin
    wr_en   = base_hit && we && access_ok;
    rd_en   = base_hit && !we && access_ok;
    base_d  = wr_en ? wdata : base_q;
    rdata_d = rd_en ? base_q : '0;
    ack_d   = (base_hit && access_ok) || key_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      base_q  <= base_d;
      rdata_q <= rdata_d;
      ack_q   <= ack_d;
    end
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!access_ok) |=> $stable(base_q)) else $error("locked register changed"); // R5

  AST_ACK_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(base_hit || key_hit)) else $error("ack without decode"); // R8

endmodule

// File: rtl/basereg_keyed_unit.sv
module basereg_keyed_unit #(
  parameter int unsigned       ADDR_W     = basereg_pkg::DEF_ADDR_W,
  parameter int unsigned       DATA_W     = basereg_pkg::DEF_DATA_W,
  parameter int unsigned       FC_W       = basereg_pkg::DEF_FC_W,
  parameter int unsigned       MODE_W     = basereg_pkg::DEF_MODE_W,
  parameter logic [MODE_W-1:0] RELOC_CODE = 3'b110,
  parameter logic [FC_W-1:0]   CPU_FC     = 3'b111,
  parameter logic [ADDR_W-1:0] HOME_ADDR  = 32'h0003_FF00,
  parameter logic [ADDR_W-1:0] RELOC_ADDR = 32'h0003_FF04,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 32'h0003_FF08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_strap,
  input  logic              cs_en_strap,
  input  logic              sel_en_pin,
  input  logic              bus_strobe,
  input  logic              bus_we,
  input  logic [FC_W-1:0]   bus_fc,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] base_value,
  output logic              base_valid
);
  import basereg_pkg::*;

  localparam int unsigned KEY_BIT = DATA_W - 1;

  logic      rst_core_n;
  map_mode_e map_mode;
  logic      straps_ready;
  logic      base_hit, key_hit;
  logic      access_ok;
  logic [DATA_W-1:0] base_q;

  basereg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  basereg_strap_capture #(.MODE_W(MODE_W), .RELOC_CODE(RELOC_CODE)) u_strap (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .mode_strap   (mode_strap),
    .cs_en_strap  (cs_en_strap),
    .map_mode     (map_mode),
    .straps_ready (straps_ready)
  );

  basereg_decode #(
    .ADDR_W(ADDR_W), .FC_W(FC_W), .HOME_ADDR(HOME_ADDR),
    .RELOC_ADDR(RELOC_ADDR), .KEY_ADDR(KEY_ADDR), .CPU_FC(CPU_FC)
  ) u_dec (
    .strobe       (bus_strobe),
    .we           (bus_we),
    .fc           (bus_fc),
    .addr         (bus_addr),
    .map_mode     (map_mode),
    .straps_ready (straps_ready),
    .base_hit     (base_hit),
    .key_hit      (key_hit)
  );

  basereg_unlock u_unlock (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .map_mode   (map_mode),
    .key_hit    (key_hit),
    .key_bit    (bus_wdata[KEY_BIT]),
    .sel_en_pin (sel_en_pin),
    .access_ok  (access_ok)
  );

  basereg_store #(.DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .base_hit  (base_hit),
    .key_hit   (key_hit),
    .we        (bus_we),
    .access_ok (access_ok),
    .wdata     (bus_wdata),
    .base_q    (base_q),
    .rdata_q   (bus_rdata),
    .ack_q     (bus_ack)
  );

  assign base_value = base_q;
  assign base_valid = base_q[0];

  AST_FC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_ack |-> ($past(bus_fc) == CPU_FC)) else $error("ack on wrong fc"); // R4

  AST_RELOC_NO_HOME: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_ack && (map_mode == MAP_RELOC)) |-> ($past(bus_addr) != HOME_ADDR))
    else $error("relocated unit answered home address"); // R3

  AST_HOME_NO_KEY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_ack && (map_mode == MAP_HOME)) |-> ($past(bus_addr) != KEY_ADDR))
    else $error("home unit answered key address"); // R10

endmodule

// File: tb/test_basereg_keyed_unit.sv
`timescale 1ns/1ps
module test_basereg_keyed_unit;

  localparam logic [31:0] A_HOME  = 32'h0003_FF00;
  localparam logic [31:0] A_RELOC = 32'h0003_FF04;
  localparam logic [31:0] A_KEY   = 32'h0003_FF08;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        rst_n;
  logic [2:0]  mode_a, mode_b;
  logic        csen_a, csen_b, pin_a, pin_b;
  logic        strobe, we;
  logic [2:0]  fc;
  logic [31:0] addr, wdata;
  logic [31:0] rdata_a, rdata_b, base_a, base_b;
  logic        ack_a, ack_b, valid_a, valid_b;

  basereg_keyed_unit i_basereg_keyed_unit (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_a), .cs_en_strap(csen_a),
    .sel_en_pin(pin_a), .bus_strobe(strobe), .bus_we(we), .bus_fc(fc),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a), .bus_ack(ack_a),
    .base_value(base_a), .base_valid(valid_a)
  );

  basereg_keyed_unit i_basereg_keyed_unit_reloc (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_b), .cs_en_strap(csen_b),
    .sel_en_pin(pin_b), .bus_strobe(strobe), .bus_we(we), .bus_fc(fc),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b), .bus_ack(ack_b),
    .base_value(base_b), .base_valid(valid_b)
  );

  typedef struct {
    int unsigned due;
    bit          ack_a, ack_b, rd_a, rd_b;
    logic [31:0] dat_a, dat_b;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  exp_t        mon_e;
  int unsigned cyc = 0;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops the expected item due in this cycle and compares.
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      mon_e = sbq.pop_front();
      checks++;
      if (ack_a !== mon_e.ack_a || ack_b !== mon_e.ack_b) begin
        failures++;
        $display("FAIL %s ack got a=%0b b=%0b exp a=%0b b=%0b", mon_e.tag,
                 ack_a, ack_b, mon_e.ack_a, mon_e.ack_b);
      end
      if (mon_e.rd_a && rdata_a !== mon_e.dat_a) begin
        failures++;
        $display("FAIL %s rdata_a got %h exp %h", mon_e.tag, rdata_a, mon_e.dat_a);
      end
      if (mon_e.rd_b && rdata_b !== mon_e.dat_b) begin
        failures++;
        $display("FAIL %s rdata_b got %h exp %h", mon_e.tag, rdata_b, mon_e.dat_b);
      end
    end else if (ack_a === 1'b1 || ack_b === 1'b1) begin
      checks++;
      failures++;
      $display("FAIL R8 stray ack got a=%0b b=%0b exp a=0 b=0", ack_a, ack_b);
    end
  end

  // Driver: one-cycle strobe, expectation pushed for the following cycle.
  task automatic access(input bit w, input logic [2:0] f, input logic [31:0] a,
                        input logic [31:0] d, input bit ea, input bit eb,
                        input bit ra, input logic [31:0] da,
                        input bit rb, input logic [31:0] db, input string tag);
    exp_t e;
    @(negedge clk);
    strobe = 1'b1; we = w; fc = f; addr = a; wdata = d;
    e.due = cyc + 1; e.ack_a = ea; e.ack_b = eb;
    e.rd_a = ra; e.dat_a = da; e.rd_b = rb; e.dat_b = db; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    strobe = 1'b0; we = 1'b0; fc = 3'b000; addr = '0; wdata = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired got running exp finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    strobe = 1'b0; we = 1'b0; fc = '0; addr = '0; wdata = '0;
    mode_a = 3'b000; csen_a = 1'b0; pin_a = 1'b0;
    mode_b = 3'b110; csen_b = 1'b0; pin_b = 1'b0;
    do_reset();

    // r1_ reset state
    chk("R1 base_a", base_a, 32'h0);
    chk("R1 base_b", base_b, 32'h0);
    chk("R1 valid", {31'b0, valid_a | valid_b}, 32'h0);

    // Straps move after capture: unit A must stay on the home map (R9).
    mode_a = 3'b110;

    access(1, 3'b111, A_HOME, 32'h1000_0001, 1, 0, 0, 0, 0, 0, "R2/R3 home write");
    chk("R2 base_a", base_a, 32'h1000_0001);
    chk("R2 valid_a", {31'b0, valid_a}, 32'h1);
    chk("R3 base_b untouched", base_b, 32'h0);
    access(0, 3'b111, A_HOME, 0, 1, 0, 1, 32'h1000_0001, 0, 0, "R8 home read");

    access(1, 3'b111, A_RELOC, 32'h2000_0001, 0, 0, 0, 0, 0, 0, "R5 locked write");
    chk("R5 base_b locked", base_b, 32'h0);
    access(0, 3'b111, A_RELOC, 0, 0, 0, 0, 0, 0, 0, "R5 locked read");

    access(1, 3'b101, A_HOME, 32'hDEAD_0000, 0, 0, 0, 0, 0, 0, "R4 bad fc");
    chk("R4 base_a kept", base_a, 32'h1000_0001);

    // Key write with pin low: acknowledged by B only, no unlock.
    access(1, 3'b111, A_KEY, 32'h8000_0000, 0, 1, 0, 0, 0, 0, "R6/R10 key pin low");
    access(1, 3'b111, A_RELOC, 32'h2000_0001, 0, 0, 0, 0, 0, 0, "R6 still locked");
    chk("R6 base_b locked", base_b, 32'h0);

    pin_b = 1'b1;
    access(1, 3'b111, A_KEY, 32'h8000_0000, 0, 1, 0, 0, 0, 0, "R6 key pin high");
    pin_b = 1'b0;
    access(1, 3'b111, A_RELOC, 32'h2000_0001, 0, 1, 0, 0, 0, 0, "R6 unlocked write");
    chk("R6 base_b", base_b, 32'h2000_0001);
    chk("R6 base_a independent", base_a, 32'h1000_0001);
    access(0, 3'b111, A_RELOC, 0, 0, 1, 0, 0, 1, 32'h2000_0001, "R8 reloc read");
    access(1, 3'b011, A_RELOC, 32'h5555_0000, 0, 0, 0, 0, 0, 0, "R4 bad fc reloc");
    chk("R4 base_b kept", base_b, 32'h2000_0001);

    pin_b = 1'b1;
    access(1, 3'b111, A_KEY, 32'h0000_0000, 0, 1, 0, 0, 0, 0, "R7 relock");
    access(1, 3'b111, A_RELOC, 32'h3000_0001, 0, 0, 0, 0, 0, 0, "R7 write after relock");
    chk("R7 base_b kept", base_b, 32'h2000_0001);
    pin_b = 1'b0;

    access(0, 3'b111, A_HOME, 0, 1, 0, 1, 32'h1000_0001, 0, 0, "R9 map kept");

    // Second reset: mode 110 with chip-select enabled stays home (R2).
    mode_a = 3'b110; csen_a = 1'b1;
    do_reset();
    chk("R1 base_b after reset", base_b, 32'h0);
    chk("R1 base_a after reset", base_a, 32'h0);
    access(1, 3'b111, A_HOME, 32'h4000_0001, 1, 0, 0, 0, 0, 0, "R2 cs enabled home");
    chk("R2 base_a cs enabled", base_a, 32'h4000_0001);
    access(1, 3'b111, A_KEY, 32'h8000_0000, 0, 1, 0, 0, 0, 0, "R10 no key in home");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule